// File: doc/BRIEF.md
# Addressed Serial Configuration Register Port

This block receives configuration words over a three-wire serial link and holds them in a bank of eight 10-bit registers. There are three inputs: serial data, a shift clock and a commit strobe. A transmitter clocks a 16-bit frame into a shift register. The frame carries, most significant bit first, a 2-bit device address, a 4-bit register address and a 10-bit value. A rising edge on the strobe then commits the frame. The frame takes effect only when its device address equals the two strap inputs, so up to four devices can share the same three wires.

The top bit of the register address turns a frame into a read request. The lower three address bits then pick a register, and the 10-bit value of that register is streamed out on a dedicated read pin, one bit per shift-clock rising edge. While a read is streaming, further commits are refused. The serial clock and the strobe are synchronised into the system clock, and their edges are detected in that domain. An asynchronous active-low reset returns every register to its default value.

Top module: `sreg_port`

## Requirements
- R1: On a strobe rising edge with matching device address and register-address bit 3 equal to 0, the register selected by address bits 2..0 takes the frame's 10 data bits. The frame is sent MSB first in the order device address [1:0], register address [3:0], data [9:0].
- R2: Serial-clock edges alone never change any register; a value is committed only by the strobe rising edge.
- R3: When more than 16 bits are shifted before the strobe, only the final 16 form the frame.
- R4: A frame whose 2-bit device address differs from `chip_id_i` changes no register and starts no read.
- R5: Reset defaults: registers 2 and 3 (gain) hold 0x040, registers 4 and 5 (black level) hold 0x050, and registers 0, 1, 6 and 7 hold 0.
- R6: A matching frame with address bit 3 equal to 1 places bit 9 of the selected register on `rdata_o`. Each following serial-clock rising edge presents the next lower bit. The tenth rising edge ends the read, and `rdata_o` is 0 whenever no read is active.
- R7: A strobe rising edge during an active read is ignored, even when the shifted frame is a valid matching write.
- R8: A read frame leaves every register unchanged.
- R9: Addresses 0 through 7 select eight independent registers: configuration, standby/delay, gain even, gain odd, black even, black odd, test mode and clock monitor.
- R10: Asserting `rst_n` low restores the defaults of R5 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial data in |
| sclk_i | input | 1 | Serial shift clock, rising-edge active |
| strobe_i | input | 1 | Commit strobe, rising-edge active |
| chip_id_i | input | 2 | Device address straps |
| rdata_o | output | 1 | Serial read-back data |
| regs_o | output | 80 | All eight registers, register k in bits [10k+9:10k] |

## Verification
The bench builds the block with its default parameters: 10-bit data, 4-bit register address, 2-bit device address and a two-stage synchroniser. With the straps tied to 2'b10, a frame addressed to another device can be sent over the same wires. The full 16-bit frame makes the over-length case and the read-then-commit overlap reachable with a handful of bits. In the overlap case, the tail of a read frame combines with six new bits to form a valid matching write, which the block must refuse while the read is streaming.

// File: rtl/sreg_port.sv
module sreg_port #(
  parameter int DW = 10,
  parameter int AW = 4,
  parameter int CW = 2,
  parameter int SYNC = 2,
  parameter logic [DW-1:0] GAIN_RST = 10'h040,
  parameter logic [DW-1:0] BLACK_RST = 10'h050
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sdata_i,
  input  logic                       sclk_i,
  input  logic                       strobe_i,
  input  logic [CW-1:0]              chip_id_i,
  output logic                       rdata_o,
  output logic [(2**(AW-1))*DW-1:0]  regs_o
);
  localparam int FW   = CW + AW + DW;
  localparam int SW   = AW - 1;
  localparam int NREG = 2**SW;
  localparam int CNTW = $clog2(DW + 1);

  logic [SYNC-1:0] sclk_q, stb_q, sdi_q;
  logic            sclk_d, stb_d;
  logic [FW-1:0]   shreg;
  logic [NREG-1:0][DW-1:0] regs;
  logic            reading;
  logic [DW-1:0]   rd_sh;
  logic [CNTW-1:0] rd_cnt;

  wire sclk_rise = sclk_q[SYNC-1] & ~sclk_d;
  wire stb_rise  = stb_q[SYNC-1] & ~stb_d;

  wire [CW-1:0] f_cid = shreg[FW-1 -: CW];
  wire          f_rd  = shreg[DW+AW-1];
  wire [SW-1:0] f_sel = shreg[DW +: SW];
  wire [DW-1:0] f_dat = shreg[DW-1:0];
  wire          hit   = stb_rise && !reading && (f_cid == chip_id_i);

  function automatic logic [DW-1:0] rst_val(input int k);
    if (k == 2 || k == 3) return GAIN_RST;
    if (k == 4 || k == 5) return BLACK_RST;
    return '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0; stb_q <= '0; sdi_q <= '0;
      sclk_d <= 1'b0; stb_d <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[SYNC-2:0], sclk_i};
      stb_q  <= {stb_q[SYNC-2:0], strobe_i};
      sdi_q  <= {sdi_q[SYNC-2:0], sdata_i};
      sclk_d <= sclk_q[SYNC-1];
      stb_d  <= stb_q[SYNC-1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) shreg <= '0;
    else if (sclk_rise) shreg <= {shreg[FW-2:0], sdi_q[SYNC-1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) regs[k] <= rst_val(k);
    end else if (hit && !f_rd) begin
      regs[f_sel] <= f_dat;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      reading <= 1'b0; rd_sh <= '0; rd_cnt <= '0;
    end else if (hit && f_rd) begin
      reading <= 1'b1; rd_sh <= regs[f_sel]; rd_cnt <= '0;
    end else if (reading && sclk_rise) begin
      rd_sh  <= {rd_sh[DW-2:0], 1'b0};
      rd_cnt <= rd_cnt + 1'b1;
      if (rd_cnt == CNTW'(DW-1)) reading <= 1'b0;
    end

  assign rdata_o = reading & rd_sh[DW-1];
  assign regs_o  = regs;

  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !f_rd) |=> regs[$past(f_sel)] == $past(f_dat));
  p_commit_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_rise |=> $stable(regs));
  p_foreign_chip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && f_cid != chip_id_i) |=> $stable(regs));
  p_read_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reading |-> rd_cnt < CNTW'(DW));
  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && reading) |=> $stable(regs));
  p_read_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && f_rd) |=> $stable(regs));
endmodule

// File: tb/sreg_port_bench.sv
module sreg_port_bench;
  logic clk = 1'b0, rst_n = 1'b0, sdata = 1'b0, sclk = 1'b0, strobe = 1'b0;
  logic [1:0] cid = 2'b10;
  logic rdata;
  logic [79:0] regs;
  logic [9:0] model [8];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sreg_port u_sreg_port (.clk(clk), .rst_n(rst_n), .sdata_i(sdata), .sclk_i(sclk),
    .strobe_i(strobe), .chip_id_i(cid), .rdata_o(rdata), .regs_o(regs));

  task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    sdata = b; wait_clk(6);
    sclk = 1'b1; wait_clk(6);
    sclk = 1'b0;
  endtask

  task automatic sbits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sbit(v[i]);
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1; wait_clk(6);
    strobe = 1'b0; wait_clk(6);
  endtask

  function automatic logic [15:0] frame(input logic [1:0] c, input logic [3:0] a, input logic [9:0] d);
    return {c, a, d};
  endfunction

  task automatic check_all(input string tag);
    for (int k = 0; k < 8; k++) check(tag, regs[k*10 +: 10], model[k]);
  endtask

  task automatic set_defaults();
    for (int k = 0; k < 8; k++) model[k] = 10'h000;
    model[2] = 10'h040; model[3] = 10'h040;
    model[4] = 10'h050; model[5] = 10'h050;
  endtask

  task automatic t_reset();
    set_defaults();
    check_all("R5 reset defaults");
    check("R6 rdata idle", {9'd0, rdata}, 10'd0);
  endtask

  task automatic t_writes();
    for (int k = 0; k < 8; k++) begin
      logic [9:0] v = 10'(10'h155 ^ (k * 37));
      sbits(frame(cid, 4'(k), v), 16);
      pulse_strobe();
      model[k] = v;
    end
    check_all("R1 R9 independent writes");
  endtask

  task automatic t_prestrobe();
    sbits(frame(cid, 4'd3, 10'h2A5), 16);
    wait_clk(8);
    check("R2 no commit before strobe", regs[30 +: 10], model[3]);
    pulse_strobe(); model[3] = 10'h2A5;
    check("R2 commit at strobe", regs[30 +: 10], model[3]);
  endtask

  task automatic t_overlength();
    sbits(16'b11011, 5);
    sbits(frame(cid, 4'd6, 10'h3C1), 16);
    pulse_strobe(); model[6] = 10'h3C1;
    check_all("R3 last sixteen bits");
  endtask

  task automatic t_foreign();
    sbits(frame(2'b01, 4'd1, 10'h0FF), 16);
    pulse_strobe();
    check_all("R4 foreign write ignored");
    sbits(frame(2'b11, 4'd9, 10'h000), 16);
    pulse_strobe();
    wait_clk(4);
    check("R4 foreign read not started", {9'd0, rdata}, 10'd0);
  endtask

  task automatic t_read(input int k);
    logic [9:0] got;
    sbits(frame(cid, 4'(8 + k), 10'h3FF), 16);
    pulse_strobe();
    for (int i = 9; i >= 0; i--) begin
      got[i] = rdata;
      sbit(1'b0);
    end
    check($sformatf("R6 read reg %0d", k), got, model[k]);
    check("R6 rdata low after read", {9'd0, rdata}, 10'd0);
    check_all("R8 read leaves regs");
  endtask

  task automatic t_busy();
    logic [9:0] got;
    logic [15:0] rf;
    rf = frame(cid, 4'd13, {cid, 4'd1, 4'b1010});
    sbits(rf, 16);
    pulse_strobe();
    for (int i = 9; i >= 4; i--) begin
      got[i] = rdata;
      sbit(i == 9 || i == 8 || i == 5 || i == 4);
    end
    pulse_strobe();
    check("R7 write refused during read", regs[10 +: 10], model[1]);
    for (int i = 3; i >= 0; i--) begin
      got[i] = rdata;
      sbit(1'b0);
    end
    check("R7 read stream intact", got, model[5]);
    sbits(frame(cid, 4'd1, 10'h2B3), 16);
    pulse_strobe(); model[1] = 10'h2B3;
    check("R7 same frame after read", regs[10 +: 10], model[1]);
  endtask

  task automatic t_async_reset();
    #1 rst_n = 1'b0;
    #1;
    set_defaults();
    check_all("R10 asynchronous reset");
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_writes();
    t_prestrobe();
    t_overlength();
    t_foreign();
    t_read(3);
    t_read(6);
    t_busy();
    t_async_reset();
    t_read(4);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule